// File: doc/BRIEF.md
# Stepper Pulse Generator with Direction Timing

This block turns a signed rate word into stepper-motor step pulses. On every clock with enable high it adds the rate to a phase accumulator. Each carry out of the accumulator asks for one forward step, and each borrow asks for one reverse step. Requests are kept in a small signed pending counter, so a request is not lost while the pulse timing is still being met. A sequencer then emits the steps. It keeps the step active for a set length, keeps a minimum idle gap between steps, and holds the direction line stable for a setup interval before each step and a hold interval after each step.

All four timing values are 16-bit clock-cycle counts, and a value of zero is treated as one cycle. Each emitted step moves a signed 32-bit position counter by one, and this counter is the position feedback. Three output encodings can be selected on two phase outputs: step with direction, separate forward and reverse pulses, and a two-phase quadrature walk that runs through one full Gray cycle per step.

The block is placed next to a host that writes a new rate every servo period and reads the position back. Position loops, acceleration limits and unit conversion are done by the host.

Top module: `step_pulse_gen`

## Requirements
- R1: After reset, `out_a` and `out_b` are 0 and `position` is 0.
- R2: On every clock with `enable` high, `rate` (signed, ACC_W bits) is added to an ACC_W-bit accumulator. A carry past 2^ACC_W requests one forward step and a borrow below 0 requests one reverse step. Once all requests have been emitted, the net change of `position` equals floor(sum of added rates / 2^ACC_W).
- R3: Requests that arrive while a step is still running are held in a signed pending count of up to 2^(PEND_W-1)-1 steps in either direction, and they are emitted later rather than dropped.
- R4: The active part of a step lasts exactly max(step_len,1) cycles. In quadrature mode each of the three non-zero phases lasts exactly max(step_len,1) cycles.
- R5: Between the end of one step and the start of the next, the outputs stay idle for at least max(step_space,1) cycles.
- R6: The direction is stable for at least max(dir_setup,1) cycles before a step starts.
- R7: The direction changes only while no step is active, and at least max(dir_hold,1) cycles after the previous step ended. A reversal waits until both the setup and the hold interval are met.
- R8: With `step_mode` 0 or 3, `out_a` is the step pulse (1 while the step is active) and `out_b` is the direction (0 forward, 1 reverse).
- R9: With `step_mode` 1, a forward step pulses only `out_a` and a reverse step pulses only `out_b`.
- R10: With `step_mode` 2, {`out_a`,`out_b`} walks 00→01→11→10→00 for each forward step and 00→10→11→01→00 for each reverse step. Only one bit changes at a time.
- R11: While `enable` is low, the accumulator and the pending count are cleared and no new step starts. Any step already running completes. After enable returns with a zero rate, `position` stays unchanged.
- R12: `position` is a signed CNT_W-bit count. It moves by +1 at the start of each forward step and by -1 at the start of each reverse step, and it does not change at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows steps to be generated |
| rate | input | ACC_W | Signed increment added to the accumulator each clock |
| step_mode | input | 2 | Output encoding: 0/3 step+dir, 1 up/down, 2 quadrature |
| step_len | input | TIME_W | Active time of a step in cycles (0 means 1) |
| step_space | input | TIME_W | Minimum idle time between steps in cycles (0 means 1) |
| dir_setup | input | TIME_W | Direction stable time before a step in cycles (0 means 1) |
| dir_hold | input | TIME_W | Direction stable time after a step in cycles (0 means 1) |
| out_a | output | 1 | Phase output A |
| out_b | output | 1 | Phase output B |
| position | output | CNT_W | Signed step count |

## Verification
The bench builds the block with ACC_W=8 and PEND_W=4. With these values a rate of a few tens produces a carry every handful of cycles, and short bursts can fill the pending counter to several steps while a slow step is still running. TIME_W and CNT_W keep their defaults. The timing registers are driven with small values, including zero, so that pulse widths, gaps and the setup and hold windows for reversals can each be measured cycle by cycle at the outputs.

// File: rtl/spg_pkg.sv
package spg_pkg;

   typedef enum logic [1:0] {
      MODE_STEPDIR = 2'd0,
      MODE_UPDN    = 2'd1,
      MODE_QUAD    = 2'd2,
      MODE_ALT     = 2'd3
   } spg_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ACT   = 2'd1,
      ST_SPACE = 2'd2
   } spg_state_e;

endpackage

// File: rtl/spg_phase_acc.sv
module spg_phase_acc #(
   parameter int ACC_W = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    enable,
   input  logic signed [ACC_W-1:0] rate,
   output logic                    req_fwd,
   output logic                    req_rev
);

   logic [ACC_W-1:0]        acc_q;
   logic signed [ACC_W+1:0] sum;

   assign sum = $signed({2'b00, acc_q}) + $signed({{2{rate[ACC_W-1]}}, rate});

   always_ff @(posedge clk) begin
      if (!rst_n || !enable) begin
         acc_q   <= '0;
         req_fwd <= 1'b0;
         req_rev <= 1'b0;
      end else begin
         acc_q   <= sum[ACC_W-1:0];
         req_fwd <= sum[ACC_W] & ~sum[ACC_W+1];
         req_rev <= sum[ACC_W+1];
      end
   end

   // R2
   fwd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_fwd |-> ($past(enable) && $past(rate) > 0));
   // R2
   rev_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_rev |-> ($past(enable) && $past(rate) < 0));

endmodule

// File: rtl/spg_step_seq.sv
module spg_step_seq
   import spg_pkg::*;
#(
   parameter int TIME_W = 16,
   parameter int CNT_W  = 32,
   parameter int PEND_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    enable,
   input  logic                    req_fwd,
   input  logic                    req_rev,
   input  logic                    quad_sel,
   input  logic [TIME_W-1:0]       step_len,
   input  logic [TIME_W-1:0]       step_space,
   input  logic [TIME_W-1:0]       dir_setup,
   input  logic [TIME_W-1:0]       dir_hold,
   output logic                    active,
   output logic [1:0]              seg,
   output logic                    dir,
   output logic signed [CNT_W-1:0] position
);

   localparam int PX_W = PEND_W + 2;
   localparam logic signed [PX_W-1:0]   P_ONE     = {{(PX_W-1){1'b0}}, 1'b1};
   localparam logic signed [PX_W-1:0]   P_MAX_EXT = {3'b000, {(PEND_W-1){1'b1}}};
   localparam logic signed [PX_W-1:0]   P_MIN_EXT = {3'b111, {(PEND_W-2){1'b0}}, 1'b1};
   localparam logic signed [PEND_W-1:0] PEND_MAX  = {1'b0, {(PEND_W-1){1'b1}}};
   localparam logic signed [PEND_W-1:0] PEND_MIN  = {1'b1, {(PEND_W-2){1'b0}}, 1'b1};

   spg_state_e               state;
   logic [TIME_W-1:0]        tmr;
   logic [TIME_W-1:0]        stable_cnt;
   logic [TIME_W-1:0]        since_end;
   logic                     dir_q;
   logic signed [PEND_W-1:0] pending;
   logic signed [PEND_W-1:0] p_nxt;
   logic signed [PX_W-1:0]   p_sum;
   logic [TIME_W-1:0]        eff_len, eff_space, eff_setup, eff_hold;
   logic                     have_req, want_rev, can_turn, start;
   logic [1:0]               last_seg;

   assign eff_len   = (step_len   == '0) ? TIME_W'(1) : step_len;
   assign eff_space = (step_space == '0) ? TIME_W'(1) : step_space;
   assign eff_setup = (dir_setup  == '0) ? TIME_W'(1) : dir_setup;
   assign eff_hold  = (dir_hold   == '0) ? TIME_W'(1) : dir_hold;
   assign last_seg  = quad_sel ? 2'd2 : 2'd0;

   assign have_req = (pending != '0);
   assign want_rev = pending[PEND_W-1];
   assign can_turn = (state == ST_IDLE) && enable && have_req && (want_rev != dir_q)
                     && (since_end >= eff_hold);
   assign start    = (state == ST_IDLE) && enable && have_req && (want_rev == dir_q)
                     && (stable_cnt >= eff_setup);

   always_comb begin
      p_sum = {{2{pending[PEND_W-1]}}, pending};
      if (req_fwd) p_sum = p_sum + P_ONE;
      if (req_rev) p_sum = p_sum - P_ONE;
      if (start)   p_sum = dir_q ? (p_sum + P_ONE) : (p_sum - P_ONE);
      if (p_sum > P_MAX_EXT)      p_nxt = PEND_MAX;
      else if (p_sum < P_MIN_EXT) p_nxt = PEND_MIN;
      else                        p_nxt = p_sum[PEND_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending <= '0;
      end else if (!enable) begin
         pending <= '0;
      end else begin
         pending <= p_nxt;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q      <= 1'b0;
         stable_cnt <= '0;
      end else if (can_turn) begin
         dir_q      <= ~dir_q;
         stable_cnt <= '0;
      end else if (~&stable_cnt) begin
         stable_cnt <= stable_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         tmr       <= '0;
         seg       <= 2'd0;
         since_end <= '1;
      end else begin
         if (~&since_end) since_end <= since_end + 1'b1;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state <= ST_ACT;
                  tmr   <= TIME_W'(1);
                  seg   <= 2'd0;
               end
            end
            ST_ACT: begin
               if (tmr >= eff_len) begin
                  tmr <= TIME_W'(1);
                  if (seg >= last_seg) begin
                     state     <= ST_SPACE;
                     seg       <= 2'd0;
                     since_end <= '0;
                  end else begin
                     seg <= seg + 2'd1;
                  end
               end else begin
                  tmr <= tmr + 1'b1;
               end
            end
            ST_SPACE: begin
               if (tmr >= eff_space) state <= ST_IDLE;
               else                  tmr   <= tmr + 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     position <= '0;
      else if (start) position <= dir_q ? (position - 1'b1) : (position + 1'b1);
   end

   assign active = (state == ST_ACT);
   assign dir    = dir_q;

   // R3
   pend_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pending == PEND_MAX) |=> !pending[PEND_W-1]);
   // R6
   dir_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ACT && $past(state) == ST_IDLE) |-> ($past(stable_cnt) >= $past(eff_setup)));
   // R7
   dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dir_q) |-> ($past(state) == ST_IDLE && $past(since_end) >= $past(eff_hold)));
   // R12
   pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (position != $past(position)) |-> ($past(state) == ST_IDLE && state == ST_ACT));
   // R11
   en_low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (pending == '0));

endmodule

// File: rtl/spg_out_enc.sv
module spg_out_enc
   import spg_pkg::*;
#(
   parameter bit HAS_QUAD = 1'b1
) (
   input  spg_mode_e  mode,
   input  logic       active,
   input  logic [1:0] seg,
   input  logic       dir,
   output logic       out_a,
   output logic       out_b
);

   if (HAS_QUAD) begin : g_quad
      always_comb begin
         case (mode)
            MODE_UPDN: begin
               out_a = active & ~dir;
               out_b = active & dir;
            end
            MODE_QUAD: begin
               if (!active) begin
                  {out_a, out_b} = 2'b00;
               end else begin
                  case (seg)
                     2'd0:    {out_a, out_b} = dir ? 2'b10 : 2'b01;
                     2'd1:    {out_a, out_b} = 2'b11;
                     default: {out_a, out_b} = dir ? 2'b01 : 2'b10;
                  endcase
               end
            end
            default: begin
               out_a = active;
               out_b = dir;
            end
         endcase
      end
   end else begin : g_noquad
      always_comb begin
         if (mode == MODE_UPDN) begin
            out_a = active & ~dir;
            out_b = active & dir;
         end else begin
            out_a = active;
            out_b = dir;
         end
      end
   end

endmodule

// File: rtl/step_pulse_gen.sv
module step_pulse_gen
   import spg_pkg::*;
#(
   parameter int ACC_W    = 32,
   parameter int TIME_W   = 16,
   parameter int CNT_W    = 32,
   parameter int PEND_W   = 8,
   parameter bit HAS_QUAD = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    enable,
   input  logic signed [ACC_W-1:0] rate,
   input  logic [1:0]              step_mode,
   input  logic [TIME_W-1:0]       step_len,
   input  logic [TIME_W-1:0]       step_space,
   input  logic [TIME_W-1:0]       dir_setup,
   input  logic [TIME_W-1:0]       dir_hold,
   output logic                    out_a,
   output logic                    out_b,
   output logic signed [CNT_W-1:0] position
);

   if (ACC_W < 4 || ACC_W > 64) begin : g_bad_acc
      $error("step_pulse_gen: ACC_W must lie in 4..64");
   end
   if (TIME_W < 2) begin : g_bad_time
      $error("step_pulse_gen: TIME_W must be at least 2");
   end
   if (PEND_W < 3) begin : g_bad_pend
      $error("step_pulse_gen: PEND_W must be at least 3");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("step_pulse_gen: CNT_W must be at least 2");
   end

   spg_mode_e  mode_e;
   logic       req_fwd, req_rev;
   logic       active, dir;
   logic [1:0] seg;
   logic       quad_sel;

   assign mode_e   = spg_mode_e'(step_mode);
   assign quad_sel = HAS_QUAD && (mode_e == MODE_QUAD);

   spg_phase_acc #(.ACC_W(ACC_W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (enable),
      .rate    (rate),
      .req_fwd (req_fwd),
      .req_rev (req_rev)
   );

   spg_step_seq #(.TIME_W(TIME_W), .CNT_W(CNT_W), .PEND_W(PEND_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .req_fwd    (req_fwd),
      .req_rev    (req_rev),
      .quad_sel   (quad_sel),
      .step_len   (step_len),
      .step_space (step_space),
      .dir_setup  (dir_setup),
      .dir_hold   (dir_hold),
      .active     (active),
      .seg        (seg),
      .dir        (dir),
      .position   (position)
   );

   spg_out_enc #(.HAS_QUAD(HAS_QUAD)) u_enc (
      .mode   (mode_e),
      .active (active),
      .seg    (seg),
      .dir    (dir),
      .out_a  (out_a),
      .out_b  (out_b)
   );

   // R10
   quad_gray_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (quad_sel && $past(quad_sel)) |-> ($countones({out_a, out_b} ^ $past({out_a, out_b})) <= 1));
   // R9
   updn_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_e == MODE_UPDN) |-> !(out_a && out_b));

endmodule

// File: tb/step_pulse_gen_tb.sv
module step_pulse_gen_tb;

   localparam int CLK_PERIOD = 10;
   localparam int ACC_W  = 8;
   localparam int PEND_W = 4;
   localparam int TIME_W = 16;
   localparam int CNT_W  = 32;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    enable = 1'b0;
   logic signed [ACC_W-1:0] rate = '0;
   logic [1:0]              mode = 2'd0;
   logic [TIME_W-1:0]       t_len = 16'd1, t_space = 16'd1, t_setup = 16'd1, t_hold = 16'd1;
   logic                    out_a, out_b;
   logic signed [CNT_W-1:0] position;

   int errors = 0;
   int checks = 0;
   int macc = 0;
   int exp_pos = 0;
   int obs_pos = 0;
   int v_len = 0, v_space = 0, v_setup = 0, v_hold = 0, v_gray = 0;
   int hi_cnt = 0, lo_cnt = 1000, dir_age = 1000, fall_age = 1000, seg_cnt = 0;
   logic prev_a = 1'b0, prev_b = 1'b0;
   logic [1:0] mon_mode = 2'd0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   step_pulse_gen #(.ACC_W(ACC_W), .TIME_W(TIME_W), .CNT_W(CNT_W), .PEND_W(PEND_W)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .rate       (rate),
      .step_mode  (mode),
      .step_len   (t_len),
      .step_space (t_space),
      .dir_setup  (t_setup),
      .dir_hold   (t_hold),
      .out_a      (out_a),
      .out_b      (out_b),
      .position   (position)
   );

   function automatic int eff(input logic [TIME_W-1:0] x);
      return (x == '0) ? 1 : int'(x);
   endfunction

   function automatic int qidx(input logic [1:0] c);
      case (c)
         2'b00:   return 0;
         2'b01:   return 1;
         2'b11:   return 2;
         default: return 3;
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // output monitor, sampled away from the active edge
   always @(negedge clk) begin
      if (!rst_n) begin
         prev_a = out_a; prev_b = out_b; mon_mode = mode; seg_cnt = 0;
      end else if (mode != mon_mode) begin
         mon_mode = mode; prev_a = out_a; prev_b = out_b; seg_cnt = 1;
      end else begin
         if (dir_age < 1000000)  dir_age++;
         if (fall_age < 1000000) fall_age++;
         if (mode == 2'd2) begin
            if ({out_a, out_b} != {prev_a, prev_b}) begin
               if ($countones({out_a, out_b} ^ {prev_a, prev_b}) != 1) v_gray++;
               else begin
                  int d;
                  d = (qidx({out_a, out_b}) - qidx({prev_a, prev_b}) + 4) % 4;
                  if ({prev_a, prev_b} != 2'b00 && seg_cnt != eff(t_len)) v_len++;
                  if ({prev_a, prev_b} == 2'b00 && lo_cnt < eff(t_space)) v_space++;
                  if ({out_a, out_b} == 2'b00) begin
                     if (d == 1) obs_pos++;
                     else if (d == 3) obs_pos--;
                  end
               end
               seg_cnt = 1;
               if ({out_a, out_b} == 2'b00) lo_cnt = 1;
            end else begin
               seg_cnt++;
               if ({out_a, out_b} == 2'b00) lo_cnt++;
            end
         end else if (mode == 2'd1) begin
            if ((out_a | out_b) && !(prev_a | prev_b)) begin
               if (lo_cnt < eff(t_space)) v_space++;
               if (out_a && out_b) v_len++;
               obs_pos += out_a ? 1 : -1;
               hi_cnt = 1;
            end else if (out_a | out_b) hi_cnt++;
            else if (prev_a | prev_b) begin
               if (hi_cnt != eff(t_len)) v_len++;
               lo_cnt = 1;
            end else lo_cnt++;
         end else begin
            if (out_b != prev_b) begin
               if (out_a || prev_a || fall_age < eff(t_hold)) v_hold++;
               dir_age = 0;
            end
            if (out_a && !prev_a) begin
               if (lo_cnt < eff(t_space)) v_space++;
               if (dir_age < eff(t_setup)) v_setup++;
               obs_pos += out_b ? -1 : 1;
               hi_cnt = 1;
            end else if (out_a) hi_cnt++;
            else if (prev_a) begin
               if (hi_cnt != eff(t_len)) v_len++;
               lo_cnt = 1;
               fall_age = 0;
            end else lo_cnt++;
         end
         prev_a = out_a;
         prev_b = out_b;
      end
   end

   task automatic fold();
      int q;
      if (macc >= 0) q = macc / (1 << ACC_W);
      else           q = -((-macc + (1 << ACC_W) - 1) / (1 << ACC_W));
      exp_pos += q;
      macc -= q * (1 << ACC_W);
   endtask

   task automatic run(input int r, input int n);
      @(negedge clk);
      rate = r[ACC_W-1:0];
      enable = 1'b1;
      repeat (n) @(posedge clk);
      macc += n * r;
      fold();
      @(negedge clk);
      rate = '0;
   endtask

   task automatic drain(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_cfg(input logic [1:0] m, input int l, input int s, input int su, input int h);
      @(negedge clk);
      mode = m;
      t_len = l[TIME_W-1:0]; t_space = s[TIME_W-1:0];
      t_setup = su[TIME_W-1:0]; t_hold = h[TIME_W-1:0];
      drain(10);
   endtask

   task automatic seg_check(input string tag);
      chk(position == exp_pos, {tag, " position vs model"}, position, exp_pos);
      chk(obs_pos == exp_pos, {tag, " observed steps vs model"}, obs_pos, exp_pos);
      chk(v_len == 0,   "R4 active length violations", v_len, 0);
      chk(v_space == 0, "R5 idle gap violations", v_space, 0);
      chk(v_setup == 0, "R6 direction setup violations", v_setup, 0);
      chk(v_hold == 0,  "R7 direction hold violations", v_hold, 0);
      chk(v_gray == 0,  "R10 Gray step violations", v_gray, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(out_a == 1'b0, "R1 out_a after reset", out_a, 0);
      chk(out_b == 1'b0, "R1 out_b after reset", out_b, 0);
      chk(position == 0, "R1 position after reset", position, 0);

      // R2 R8 R12 step/dir, forward then reverse
      set_cfg(2'd0, 3, 2, 2, 2);
      run(40, 300);  drain(100);
      seg_check("R2 R12 fwd stepdir");
      run(-40, 300); drain(100);
      seg_check("R8 R12 rev stepdir");

      // R4 R5 zero timing registers act as one cycle
      set_cfg(2'd0, 0, 0, 0, 0);
      run(80, 200); drain(100);
      seg_check("R4 zero timing");

      // R3 burst faster than service, requests held pending
      run(120, 30); drain(100);
      seg_check("R3 burst held");
      run(-120, 30); drain(100);
      seg_check("R3 reverse burst held");

      // R8 mode 3 behaves as step/dir
      set_cfg(2'd3, 2, 2, 1, 1);
      run(30, 200); run(-30, 200); drain(150);
      seg_check("R8 mode3");

      // R9 up/down pulses
      set_cfg(2'd1, 2, 3, 1, 1);
      run(30, 200); run(-30, 200); drain(150);
      seg_check("R9 updown");

      // R10 quadrature both ways
      set_cfg(2'd2, 2, 1, 1, 1);
      run(20, 300); drain(150);
      seg_check("R10 quad fwd");
      run(-20, 300); drain(150);
      seg_check("R10 quad rev");

      // R6 R7 repeated reversals with long setup and hold
      set_cfg(2'd0, 2, 2, 5, 4);
      for (int i = 0; i < 4; i++) begin
         run(30, 60);
         run(-30, 60);
      end
      drain(200);
      seg_check("R6 R7 reversals");

      // R11 enable low: no steps, pending discarded
      begin
         int p0;
         int o0;
         @(negedge clk);
         p0 = position; o0 = obs_pos;
         enable = 1'b0; rate = 8'sd64;
         drain(100);
         chk(position == p0, "R11 position while disabled", position, p0);
         chk(obs_pos == o0, "R11 no pulses while disabled", obs_pos, o0);
         rate = '0; enable = 1'b1;
         macc = 0;
         set_cfg(2'd0, 3, 3, 1, 1);
         run(100, 20);
         @(negedge clk);
         enable = 1'b0;
         drain(50);
         p0 = position;
         enable = 1'b1;
         drain(100);
         chk(position == p0, "R11 pending cleared by disable", position, p0);
         chk(obs_pos == p0, "R11 observed steps vs position", obs_pos, p0);
         exp_pos = obs_pos;
         macc = 0;
      end

      // random segments
      for (int k = 0; k < 12; k++) begin
         int r;
         set_cfg(2'($urandom_range(3)), int'($urandom_range(3)), int'($urandom_range(3)),
                 int'($urandom_range(3)), int'($urandom_range(3)));
         r = int'($urandom_range(16)) - 8;
         run(r, 400);
         drain(300);
         seg_check("R2 R12 random");
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule